// File: doc/BRIEF.md
# Halfword Pack Execute Unit

This block executes the two halfword-pack data-processing operations of a 32-bit load/store processor core. It receives an instruction word with a valid strobe, together with the current condition flags. It drives the two source register indices straight back out, so the register file can return both operands in the same cycle. It then evaluates the 4-bit condition field and builds the packed result. One cycle later it presents a registered write request: a write-enable, a destination index and a 32-bit result.

Two forms are supported. The low-keep form keeps the low half of the first operand and takes the high half from the second operand after a logical left shift. The high-keep form keeps the high half of the first operand and takes the low half from the second operand after an arithmetic right shift. In the high-keep form, a shift field of zero means a shift of 31.

Any other word is reported as unhandled, and no write is requested for it. The block never writes state by itself; the pipeline that surrounds it commits the request. The input stream carries only a valid strobe and has no ready signal. The unit accepts a word on every cycle that `in_valid` is high, so it never applies back-pressure. `out_valid` marks each result cycle, and the consumer must take every result in the cycle it appears.

Top module: `hpk_unit`

## Requirements
- R1: `rs_a_idx` equals instruction bits 19:16 and `rs_b_idx` equals bits 3:0, combinationally in the same cycle. The register file returns `rs_a_data` and `rs_b_data` for those indices in that same cycle.
- R2: A word is handled only when bits 27:20 equal 8'h68 and bits 6:4 equal 3'b001 (low-keep form) or 3'b101 (high-keep form). For any other word, `unhandled` is 1 and `wr_en` is 0 in the result cycle.
- R3: The result cycle is the cycle after `in_valid` is sampled high. `out_valid` is 1 in that cycle and 0 after a cycle with `in_valid` low. `wr_en` and `unhandled` are only ever 1 while `out_valid` is 1.
- R4: A synchronous active-high `rst` clears `out_valid`, `wr_en` and `unhandled`.
- R5: `wr_idx` equals bits 15:12 of the accepted word.
- R6: In the low-keep form, `wr_data[15:0]` is the first operand's bits 15:0. `wr_data[31:16]` is bits 31:16 of (second operand logically shifted left by bits 11:7).
- R7: In the low-keep form with a shift of 0, `wr_data[31:16]` equals the second operand's unshifted bits 31:16.
- R8: In the high-keep form, `wr_data[31:16]` is the first operand's bits 31:16. `wr_data[15:0]` is bits 15:0 of (second operand arithmetically shifted right by bits 11:7).
- R9: In the high-keep form, a shift field of 0 acts as a shift of 31, so every bit of `wr_data[15:0]` is a copy of the second operand's bit 31.
- R10: The condition is taken from bits 31:28, and the flags are ordered `flags[3]`=N, `flags[2]`=Z, `flags[1]`=C, `flags[0]`=V. The codes are: 0 Z; 1 !Z; 2 C; 3 !C; 4 N; 5 !N; 6 V; 7 !V; 8 C&!Z; 9 !C|Z; A N==V; B N!=V; C !Z&(N==V); D Z|(N!=V). When the condition fails on a handled word, `wr_en` is 0, `unhandled` is 0 and `out_valid` is 1.
- R11: Code 4'hE always passes and code 4'hF never passes, whatever the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction word valid this cycle |
| instr | input | 32 | Instruction word |
| flags | input | 4 | Condition flags N,Z,C,V (bit 3 down to bit 0) |
| rs_a_idx | output | 4 | First operand read index |
| rs_b_idx | output | 4 | Second operand read index |
| rs_a_data | input | 32 | First operand read data |
| rs_b_data | input | 32 | Second operand read data |
| out_valid | output | 1 | Result cycle marker |
| wr_en | output | 1 | Write request to destination |
| wr_idx | output | 4 | Destination register index |
| wr_data | output | 32 | Packed result |
| unhandled | output | 1 | Accepted word is not a pack operation |

## Verification
The bench drives the high-keep form with a zero shift on both negative and positive second operands. A unit that treated zero as no shift would pass the low half through unchanged instead of filling it with the sign bit. Large shift amounts on negative operands separate an arithmetic shift from a logical one, because a logical shift leaves zeros where the sign bit should be copied. The bench sweeps all sixteen condition codes against flag patterns chosen to make each code both pass and fail, which exposes a swapped or inverted code. Words that differ from a pack word in one opcode bit or in the bit-5 pattern must raise `unhandled` and suppress the write; a loose match would write a spurious result.

// File: rtl/hpk_pkg.sv
package hpk_pkg;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned HALF_W  = WORD_W / 2;
  localparam int unsigned IDX_W   = 4;
  localparam int unsigned SHAMT_W = 5;
  localparam int unsigned COND_W  = 4;
  localparam logic [7:0]  MAJOR_OP   = 8'h68;
  localparam logic [2:0]  SUB_LOKEEP = 3'b001;
  localparam logic [2:0]  SUB_HIKEEP = 3'b101;
  localparam logic [WORD_W-1:0] LO_MASK = {{HALF_W{1'b0}}, {HALF_W{1'b1}}};
  localparam logic [WORD_W-1:0] HI_MASK = {{HALF_W{1'b1}}, {HALF_W{1'b0}}};

  typedef enum logic [0:0] {
    PK_LOKEEP = 1'b0,
    PK_HIKEEP = 1'b1
  } pk_form_e;

  typedef struct packed {
    logic               hit;
    pk_form_e           form;
    logic [COND_W-1:0]  cond;
    logic [IDX_W-1:0]   dst;
    logic [IDX_W-1:0]   src_a;
    logic [IDX_W-1:0]   src_b;
    logic [SHAMT_W-1:0] shamt;
  } pk_dec_t;
endpackage

// File: rtl/hpk_decode.sv
module hpk_decode
  import hpk_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  output pk_dec_t           dec
);
  logic [7:0] major;
  logic [2:0] sub;
  logic       is_lo;
  logic       is_hi;

  assign major = word[27:20];
  assign sub   = word[6:4];
  assign is_lo = (sub == SUB_LOKEEP);
  assign is_hi = (sub == SUB_HIKEEP);

  always_comb begin
    dec.hit   = (major == MAJOR_OP) && (is_lo || is_hi);
    dec.form  = is_hi ? PK_HIKEEP : PK_LOKEEP;
    dec.cond  = word[31:28];
    dec.src_a = word[19:16];
    dec.dst   = word[15:12];
    dec.shamt = word[11:7];
    dec.src_b = word[3:0];
  end
endmodule

// File: rtl/hpk_cond.sv
module hpk_cond
  import hpk_pkg::*;
(
  input  logic [COND_W-1:0] code,
  input  logic [3:0]        nzcv,
  output logic              pass
);
  logic n, z, c, v, ge;
  assign n  = nzcv[3];
  assign z  = nzcv[2];
  assign c  = nzcv[1];
  assign v  = nzcv[0];
  assign ge = (n == v);

  // Pairs of codes share a test; bit 0 inverts it (except 4'hE / 4'hF).
  logic base;
  always_comb begin
    unique case (code[3:1])
      3'd0:    base = z;
      3'd1:    base = c;
      3'd2:    base = n;
      3'd3:    base = v;
      3'd4:    base = c & ~z;
      3'd5:    base = ge;
      3'd6:    base = ~z & ge;
      default: base = 1'b1;
    endcase
  end

  always_comb begin
    if (code[3:1] == 3'd7) pass = ~code[0];
    else                   pass = base ^ code[0];
  end

  always_comb begin
    p_never_r11: assert (!((code == 4'hF) && pass));
  end
endmodule

// File: rtl/hpk_pack_alu.sv
module hpk_pack_alu
  import hpk_pkg::*;
(
  input  pk_form_e           form,
  input  logic [SHAMT_W-1:0] shamt,
  input  logic [WORD_W-1:0]  op_a,
  input  logic [WORD_W-1:0]  op_b,
  output logic [WORD_W-1:0]  result
);
  localparam logic [SHAMT_W-1:0] MAX_SH = {SHAMT_W{1'b1}};

  logic [SHAMT_W-1:0] sh_right;
  logic [WORD_W-1:0]  shl;
  logic [WORD_W-1:0]  sra;
  logic [WORD_W-1:0]  res_lo_keep;
  logic [WORD_W-1:0]  res_hi_keep;

  // A zero shift field in the high-keep form encodes the widest shift.
  assign sh_right = (shamt == '0) ? MAX_SH : shamt;
  assign shl      = op_b << shamt;
  assign sra      = WORD_W'($signed(op_b) >>> sh_right);

  assign res_lo_keep = (op_a & LO_MASK) | (shl & HI_MASK);
  assign res_hi_keep = (sra & LO_MASK) | (op_a & HI_MASK);

  always_comb begin
    unique case (form)
      PK_HIKEEP: result = res_hi_keep;
      default:   result = res_lo_keep;
    endcase
  end
endmodule

// File: rtl/hpk_unit.sv
module hpk_unit
  import hpk_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] instr,
  input  logic [3:0]        flags,
  output logic [IDX_W-1:0]  rs_a_idx,
  output logic [IDX_W-1:0]  rs_b_idx,
  input  logic [WORD_W-1:0] rs_a_data,
  input  logic [WORD_W-1:0] rs_b_data,
  output logic              out_valid,
  output logic              wr_en,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [WORD_W-1:0] wr_data,
  output logic              unhandled
);
  pk_dec_t           dec;
  logic              cond_ok;
  logic [WORD_W-1:0] pack_res;

  hpk_decode u_decode (
    .word (instr),
    .dec  (dec)
  );

  hpk_cond u_cond (
    .code (dec.cond),
    .nzcv (flags),
    .pass (cond_ok)
  );

  hpk_pack_alu u_alu (
    .form   (dec.form),
    .shamt  (dec.shamt),
    .op_a   (rs_a_data),
    .op_b   (rs_b_data),
    .result (pack_res)
  );

  assign rs_a_idx = dec.src_a;
  assign rs_b_idx = dec.src_b;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      wr_en     <= 1'b0;
      unhandled <= 1'b0;
    end else begin
      out_valid <= in_valid;
      wr_en     <= in_valid & dec.hit & cond_ok;
      unhandled <= in_valid & ~dec.hit;
    end
  end

  always_ff @(posedge clk) begin
    if (in_valid) begin
      wr_idx  <= dec.dst;
      wr_data <= pack_res;
    end
  end

  p_wr_in_slot_r3: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> out_valid);

  p_unhandled_no_wr_r2: assert property (@(posedge clk) disable iff (rst)
    unhandled |-> !wr_en);

  p_idle_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && !wr_en && !unhandled));

  p_always_writes_r11: assert property (@(posedge clk) disable iff (rst)
    (in_valid && dec.hit && instr[31:28] == 4'hE) |=> wr_en);

  p_never_writes_r11: assert property (@(posedge clk) disable iff (rst)
    (in_valid && instr[31:28] == 4'hF) |=> (!wr_en && out_valid));
endmodule

// File: tb/hpk_unit_tb.sv
module hpk_unit_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [31:0] instr;
  logic [3:0]  flags;
  logic [3:0]  rs_a_idx, rs_b_idx;
  logic [31:0] rs_a_data, rs_b_data;
  logic        out_valid, wr_en, unhandled;
  logic [3:0]  wr_idx;
  logic [31:0] wr_data;

  int n_checks = 0;
  int n_errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hpk_unit u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .instr(instr), .flags(flags),
    .rs_a_idx(rs_a_idx), .rs_b_idx(rs_b_idx),
    .rs_a_data(rs_a_data), .rs_b_data(rs_b_data),
    .out_valid(out_valid), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .unhandled(unhandled)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] enc(input logic [3:0] cnd, input logic [7:0] maj,
      input logic [3:0] rn, input logic [3:0] rd, input logic [4:0] sh,
      input logic [2:0] sub, input logic [3:0] rm);
    return {cnd, maj, rn, rd, sh, sub, rm};
  endfunction

  function automatic logic [31:0] m_lokeep(input logic [31:0] a, input logic [31:0] b,
                                           input logic [4:0] sh);
    logic [31:0] t;
    t = b << sh;
    return {t[31:16], a[15:0]};
  endfunction

  function automatic logic [31:0] m_hikeep(input logic [31:0] a, input logic [31:0] b,
                                           input logic [4:0] sh);
    logic [31:0] t;
    int s;
    s = (sh == 0) ? 31 : int'(sh);
    t = 32'($signed(b) >>> s);
    return {a[31:16], t[15:0]};
  endfunction

  function automatic bit m_cond(input logic [3:0] c, input logic [3:0] f);
    bit n, z, cy, v;
    {n, z, cy, v} = f;
    case (c)
      4'h0: return z;         4'h1: return !z;
      4'h2: return cy;        4'h3: return !cy;
      4'h4: return n;         4'h5: return !n;
      4'h6: return v;         4'h7: return !v;
      4'h8: return cy && !z;  4'h9: return !cy || z;
      4'hA: return n == v;    4'hB: return n != v;
      4'hC: return !z && (n == v);
      4'hD: return z || (n != v);
      4'hE: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  // Drive one word at the falling edge, sample results one cycle later.
  task automatic issue(input logic [31:0] w, input logic [3:0] f,
                       input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    in_valid = 1'b1; instr = w; flags = f; rs_a_data = a; rs_b_data = b;
    #1;
    check(rs_a_idx == w[19:16], "R1 a-index", 32'(rs_a_idx), 32'(w[19:16]));
    check(rs_b_idx == w[3:0],   "R1 b-index", 32'(rs_b_idx), 32'(w[3:0]));
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic t_reset;
    rst = 1'b1; in_valid = 1'b1;
    instr = enc(4'hE, 8'h68, 4'd1, 4'd2, 5'd0, 3'b001, 4'd3);
    flags = 4'h0; rs_a_data = '0; rs_b_data = '0;
    repeat (3) @(posedge clk);
    #1;
    check(!out_valid && !wr_en && !unhandled, "R4 reset clears",
          {29'd0, out_valid, wr_en, unhandled}, 32'd0);
    @(negedge clk); rst = 1'b0; in_valid = 1'b0;
  endtask

  task automatic t_lokeep;
    logic [31:0] a = 32'hAAAA_1234, b = 32'h8765_4321;
    logic [4:0] shs [4] = '{5'd0, 5'd4, 5'd16, 5'd31};
    foreach (shs[i]) begin
      logic [31:0] exp = m_lokeep(a, b, shs[i]);
      issue(enc(4'hE, 8'h68, 4'd5, 4'(i + 6), shs[i], 3'b001, 4'd9), 4'h0, a, b);
      check(out_valid && wr_en && !unhandled, "R3 lokeep slot",
            {29'd0, out_valid, wr_en, unhandled}, 32'd6);
      check(wr_idx == 4'(i + 6), "R5 dst index", 32'(wr_idx), 32'(i + 6));
      check(wr_data == exp, (shs[i] == 0) ? "R7 lokeep zero shift" : "R6 lokeep",
            wr_data, exp);
    end
  endtask

  task automatic t_hikeep;
    logic [31:0] as [5] = '{32'h1357_AAAA, 32'hFFFF_0000, 32'h0000_FFFF, 32'h2468_1111, 32'hABCD_0001};
    logic [31:0] bs [5] = '{32'h8000_0000, 32'h7FFF_FFFF, 32'h8123_4567, 32'h8123_4567, 32'h0F0F_F0F0};
    logic [4:0]  ss [5] = '{5'd0, 5'd0, 5'd16, 5'd28, 5'd3};
    foreach (ss[i]) begin
      logic [31:0] exp = m_hikeep(as[i], bs[i], ss[i]);
      issue(enc(4'hE, 8'h68, 4'd2, 4'd11, ss[i], 3'b101, 4'd4), 4'h0, as[i], bs[i]);
      check(wr_en && !unhandled, "R3 hikeep write", {30'd0, wr_en, unhandled}, 32'd2);
      check(wr_data == exp, (ss[i] == 0) ? "R9 hikeep zero shift" : "R8 hikeep",
            wr_data, exp);
    end
  endtask

  task automatic t_conditions;
    logic [3:0] fl [6] = '{4'b0000, 4'b0100, 4'b0010, 4'b1001, 4'b1000, 4'b1111};
    for (int c = 0; c < 16; c++) begin
      foreach (fl[j]) begin
        bit expw = m_cond(4'(c), fl[j]);
        issue(enc(4'(c), 8'h68, 4'd1, 4'd1, 5'd8, 3'b001, 4'd2), fl[j],
              32'h0, 32'h00FF_0000);
        check(out_valid && !unhandled, "R10 slot valid, handled",
              {30'd0, out_valid, unhandled}, 32'd2);
        check(wr_en == expw, (c >= 14) ? "R11 fixed code" : "R10 condition",
              32'(wr_en), 32'(expw));
      end
    end
  endtask

  task automatic t_unhandled;
    logic [31:0] ws [4] = '{
      enc(4'hE, 8'h69, 4'd1, 4'd2, 5'd0, 3'b001, 4'd3),
      enc(4'hE, 8'h68, 4'd1, 4'd2, 5'd0, 3'b011, 4'd3),
      enc(4'hE, 8'h68, 4'd1, 4'd2, 5'd0, 3'b000, 4'd3),
      enc(4'hE, 8'h48, 4'd1, 4'd2, 5'd0, 3'b101, 4'd3)};
    foreach (ws[i]) begin
      issue(ws[i], 4'h0, 32'h1111_2222, 32'h3333_4444);
      check(out_valid && unhandled && !wr_en, "R2 unhandled",
            {29'd0, out_valid, unhandled, wr_en}, 32'd6);
    end
  endtask

  task automatic t_idle;
    issue(enc(4'hE, 8'h68, 4'd1, 4'd2, 5'd0, 3'b001, 4'd3), 4'h0, 32'h1, 32'h2);
    @(posedge clk); #1;
    check(!out_valid && !wr_en && !unhandled, "R3 idle after valid",
          {29'd0, out_valid, wr_en, unhandled}, 32'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_checks++; n_errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    t_reset();
    t_lokeep();
    t_hikeep();
    t_conditions();
    t_unhandled();
    t_idle();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule